// File: doc/BRIEF.md
# Shift-Register LCD Refresh DMA Controller

This block refreshes a panel driven through a shift-register LCD driver. Software programs a display-memory start address, a byte count for the frame, a gray-scale level and the LCD clock source, then writes the go register. The block then raises a bus request to the CPU. Once the grant is seen, it reads the frame byte by byte from memory, and the CPU stays stalled for the whole time. Each byte is presented on an 8-bit LCD data bus together with a one-cycle shift strobe.

Line-latch, frame and alternation strobes are timed from an LCD clock rather than the system clock. The LCD clock is a per-cycle enable taken from either a low-frequency oscillator tick or a timer tick, and a control bit picks the source at run time. After every line of `LINE_BYTES` bytes, and after the last byte of the frame, the sequencer pauses until the next LCD tick and then issues the latch strobe. On the final latch it also pulses the frame strobe, flips the alternation output and releases the bus.

Top module: `lcd_sr_refresh`

## Requirements
- R1: After reset, bus_req, busy, mem_rd, lcd_shift, lcd_latch, lcd_frame and lcd_alt are all 0, and lcd_gray is 0.
- R2: A write with wr_sel=3 while idle, with a non-zero size, raises bus_req and busy in the next cycle. mem_rd stays 0 until bus_gnt has been seen high while the request is up.
- R3: One frame issues exactly `size` reads. The first is at the start address (wr_sel=0), and each later read is one byte higher. The size is written with wr_sel=1.
- R4: The byte returned on mem_rdata in the cycle after a read appears on lcd_data in the following cycle, with lcd_shift high for exactly that one cycle.
- R5: lcd_latch pulses for one cycle after every LINE_BYTES bytes and after the last byte. Each pulse comes one cycle after a cycle in which the selected LCD tick was high.
- R6: lcd_frame pulses exactly once per frame, in the same cycle as the final latch pulse, and lcd_alt inverts in that cycle.
- R7: bus_req and busy fall in the same cycle in which lcd_frame is high.
- R8: Control register (wr_sel=2) bit 0 selects the LCD tick source: 0 for lf_tick, 1 for tmr_tick. Reset clears it to 0.
- R9: A go write while busy is ignored: the running frame keeps its address and byte count and no second frame follows.
- R10: A go write with a programmed size of 0 is ignored: bus_req stays 0.
- R11: Control register bits 2:1 are the gray-scale level and appear on lcd_gray in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start address, 1 size, 2 control, 3 go |
| wr_data | input | ADDR_W | Register write data |
| busy | output | 1 | High from go until the bus is released |
| lf_tick | input | 1 | Low-frequency oscillator tick, one clk cycle wide |
| tmr_tick | input | 1 | Timer tick, one clk cycle wide |
| bus_req | output | 1 | Bus release request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| lcd_data | output | 8 | LCD data bus |
| lcd_shift | output | 1 | Data shift strobe |
| lcd_latch | output | 1 | Line latch strobe |
| lcd_frame | output | 1 | Frame strobe |
| lcd_alt | output | 1 | Alternation signal |
| lcd_gray | output | 2 | Programmed gray-scale level |

## Verification
The hardest case to reach from the ports is a line end or frame end that waits on a rare LCD tick while the unselected tick keeps firing. Only then would a swapped source or an unpaced strobe show up. The stimulus drives both tick inputs at independent random rates and flips the source bit between frames. It also uses random sizes that land both on and off line boundaries, including a size of one byte. A directed go issued in the middle of a frame, and another issued with a size of zero, cover the two ignored-start cases.

// File: rtl/lcd_sr_pkg.sv
// Shared constants and types for the LCD refresh controller.
// Assumes: register selects are 2 bits wide.
package lcd_sr_pkg;
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_SIZE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_GO   = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_READ,
        ST_SHIFT,
        ST_LWAIT
    } seq_state_t;
endpackage

// File: rtl/lcd_sr_regs.sv
// Register file: start address, frame size, clock select and gray level.
// It also generates a single-cycle go pulse.
// Assumes: go is qualified here, so the sequencer never sees a go while busy
// or while the size is 0.
module lcd_sr_regs
    import lcd_sr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              busy,
    output logic [ADDR_W-1:0] start_addr,
    output logic [SIZE_W-1:0] frame_size,
    output logic              clk_sel,
    output logic [1:0]        gray,
    output logic              go
);
    // Holds the programmed registers; all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            frame_size <= '0;
            clk_sel    <= 1'b0;
            gray       <= 2'd0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDR: start_addr <= wr_data;
                SEL_SIZE: frame_size <= wr_data[SIZE_W-1:0];
                SEL_CTRL: begin
                    clk_sel <= wr_data[0];
                    gray    <= wr_data[2:1];
                end
                default: ;
            endcase
        end
    end

    // A go is honoured only when idle and when the size is non-zero.
    always_comb go = wr_en && (wr_sel == SEL_GO) && !busy && (frame_size != '0);
endmodule

// File: rtl/lcd_sr_clk_sel.sv
// LCD clock source selection between two tick enables.
// Assumes: both ticks are synchronous one-cycle pulses in the clk domain.
module lcd_sr_clk_sel (
    input  logic sel,
    input  logic lf_tick,
    input  logic tmr_tick,
    output logic lcd_tick
);
    // Chooses the tick that paces the line and frame strobes.
    always_comb lcd_tick = sel ? tmr_tick : lf_tick;
endmodule

// File: rtl/lcd_sr_seq.sv
// Frame sequencer: handles the bus handshake, issues the memory reads and
// drives the LCD data and strobes.
// Assumes: bus_gnt stays high while bus_req is high, and read data arrives
// one cycle after mem_rd.
module lcd_sr_seq
    import lcd_sr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 12,
    parameter int LINE_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [SIZE_W-1:0] frame_size,
    input  logic              lcd_tick,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        lcd_data,
    output logic              lcd_shift,
    output logic              lcd_latch,
    output logic              lcd_frame,
    output logic              lcd_alt
);
    localparam int LINE_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINE_BYTES - 1);

    seq_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] left_q;
    logic [LINE_W-1:0] line_q;

    // Main state machine with the address, remaining-byte and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            left_q    <= '0;
            line_q    <= '0;
            lcd_data  <= 8'd0;
            lcd_shift <= 1'b0;
            lcd_latch <= 1'b0;
            lcd_frame <= 1'b0;
            lcd_alt   <= 1'b0;
        end else begin
            lcd_shift <= 1'b0;
            lcd_latch <= 1'b0;
            lcd_frame <= 1'b0;
            case (state)
                ST_IDLE: if (go) begin
                    addr_q <= start_addr;
                    left_q <= frame_size;
                    line_q <= '0;
                    state  <= ST_REQ;
                end
                ST_REQ: if (bus_gnt) state <= ST_READ;
                ST_READ: state <= ST_SHIFT;
                ST_SHIFT: begin
                    lcd_data  <= mem_rdata;
                    lcd_shift <= 1'b1;
                    addr_q    <= addr_q + 1'b1;
                    left_q    <= left_q - 1'b1;
                    if (left_q == SIZE_W'(1) || line_q == LINE_LAST) begin
                        line_q <= '0;
                        state  <= ST_LWAIT;
                    end else begin
                        line_q <= line_q + 1'b1;
                        state  <= ST_READ;
                    end
                end
                ST_LWAIT: if (lcd_tick) begin
                    lcd_latch <= 1'b1;
                    if (left_q == '0) begin
                        lcd_frame <= 1'b1;
                        lcd_alt   <= ~lcd_alt;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus request covers the whole frame; a read is issued in the READ state.
    always_comb begin
        bus_req  = (state != ST_IDLE);
        mem_rd   = (state == ST_READ);
        mem_addr = addr_q;
    end

    // R2
    rd_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> bus_req);
    // R5
    latch_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_latch |-> $past(lcd_tick));
    // R6
    alt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_frame |-> (lcd_alt != $past(lcd_alt)) && lcd_latch);
    // R7
    frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> lcd_frame);
    // R4
    shift_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_shift |=> !lcd_shift);
endmodule

// File: rtl/lcd_sr_refresh.sv
// Top level of the shift-register LCD refresh controller.
// Assumes: every input is synchronous to clk and ticks are one cycle wide.
module lcd_sr_refresh
    import lcd_sr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 12,
    parameter int LINE_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              busy,
    input  logic              lf_tick,
    input  logic              tmr_tick,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        lcd_data,
    output logic              lcd_shift,
    output logic              lcd_latch,
    output logic              lcd_frame,
    output logic              lcd_alt,
    output logic [1:0]        lcd_gray
);
    logic [ADDR_W-1:0] start_addr;
    logic [SIZE_W-1:0] frame_size;
    logic              clk_sel;
    logic              go;
    logic              lcd_tick;

    lcd_sr_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .start_addr(start_addr),
        .frame_size(frame_size), .clk_sel(clk_sel), .gray(lcd_gray), .go(go)
    );

    lcd_sr_clk_sel u_clk (
        .sel(clk_sel), .lf_tick(lf_tick), .tmr_tick(tmr_tick), .lcd_tick(lcd_tick)
    );

    lcd_sr_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .frame_size(frame_size), .lcd_tick(lcd_tick), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .lcd_data(lcd_data), .lcd_shift(lcd_shift),
        .lcd_latch(lcd_latch), .lcd_frame(lcd_frame), .lcd_alt(lcd_alt)
    );

    // Busy mirrors the bus request for the whole frame.
    always_comb busy = bus_req;
endmodule

// File: tb/sim_lcd_sr_refresh.sv
module sim_lcd_sr_refresh;
    localparam int ADDR_W = 16;
    localparam int LINE_BYTES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [ADDR_W-1:0] wr_data = '0;
    logic busy, bus_req, mem_rd, lcd_shift, lcd_latch, lcd_frame, lcd_alt;
    logic lf_tick = 1'b0, tmr_tick = 1'b0, bus_gnt = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rdata = 8'd0, lcd_data;
    logic [1:0] lcd_gray;

    int errors = 0, checks = 0;
    bit finished = 0;

    lcd_sr_refresh u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .lf_tick(lf_tick), .tmr_tick(tmr_tick), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .lcd_data(lcd_data), .lcd_shift(lcd_shift), .lcd_latch(lcd_latch),
        .lcd_frame(lcd_frame), .lcd_alt(lcd_alt), .lcd_gray(lcd_gray)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic int exp_latches(input int size);
        return (size + LINE_BYTES - 1) / LINE_BYTES;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model: data is returned in the cycle after a read.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

    // Tick sources at independent random rates; grant after a random delay.
    int lf_div = 5, tmr_div = 3, gnt_wait = 0;
    always @(posedge clk) begin
        #1;
        lf_tick  = ($urandom % lf_div) == 0;
        tmr_tick = ($urandom % tmr_div) == 0;
        if (!bus_req) bus_gnt = 1'b0;
        else if (!bus_gnt) begin
            if (gnt_wait == 0) bus_gnt = 1'b1;
            else gnt_wait--;
        end
    end

    // Monitor state for the frame in progress.
    bit sel_now = 0;
    logic [ADDR_W-1:0] cur_addr;
    int reads = 0, bytes = 0, latches = 0, frames = 0;
    bit prev_tick = 0, gnt_seen = 0, prev_req = 0;

    always @(negedge clk) if (rst_n) begin
        if (mem_rd) begin
            check(gnt_seen, "R2 read before grant", 0, 1);
            check(mem_addr == cur_addr + ADDR_W'(reads), "R3 read address",
                  mem_addr, cur_addr + ADDR_W'(reads));
            reads++;
        end
        if (lcd_shift) begin
            check(lcd_data == mem_byte(cur_addr + ADDR_W'(bytes)), "R4 lcd byte",
                  lcd_data, mem_byte(cur_addr + ADDR_W'(bytes)));
            bytes++;
        end
        if (lcd_latch) begin
            check(prev_tick, "R5/R8 latch without selected tick", 0, 1);
            latches++;
        end
        if (lcd_frame) frames++;
        if (prev_req && !bus_req)
            check(lcd_frame, "R7 release without frame strobe", lcd_frame, 1);
        if (bus_req && bus_gnt) gnt_seen = 1;
        if (!bus_req) gnt_seen = 0;
        prev_req  = bus_req;
        prev_tick = sel_now ? tmr_tick : lf_tick;
    end

    task automatic write_reg(input logic [1:0] sel, input logic [ADDR_W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [ADDR_W-1:0] a, input int size,
                             input bit sel, input bit poke_busy);
        bit alt0;
        write_reg(2'd0, a);
        write_reg(2'd1, ADDR_W'(size));
        write_reg(2'd2, {13'd0, 2'd0, sel});
        sel_now = sel;
        cur_addr = a; reads = 0; bytes = 0; latches = 0; frames = 0;
        gnt_wait = $urandom % 6;
        alt0 = lcd_alt;
        write_reg(2'd3, '0);
        // The write completes one edge before the task returns.
        check(bus_req && busy, "R2 request after go", bus_req, 1);
        if (poke_busy) begin
            repeat (3) @(posedge clk);
            write_reg(2'd0, a + 16'h100);
            write_reg(2'd3, '0);   // R9: must be ignored
        end
        while (bus_req) @(negedge clk);
        repeat (20) @(negedge clk);
        check(reads == size, "R3 read count", reads, size);
        check(bytes == size, "R4 shift count", bytes, size);
        check(latches == exp_latches(size), "R5 latch count", latches, exp_latches(size));
        check(frames == 1, "R6 frame count", frames, 1);
        check(lcd_alt == !alt0, "R6 alternation flip", lcd_alt, !alt0);
        check(!bus_req && !busy, "R7/R9 idle after frame", bus_req, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !busy && !mem_rd, "R1 bus idle", bus_req, 0);
        check(!lcd_shift && !lcd_latch && !lcd_frame && !lcd_alt, "R1 strobes low", lcd_alt, 0);
        check(lcd_gray == 2'd0, "R1 gray", lcd_gray, 0);
        // R8: default source after reset is lf_tick (sel_now stays 0 without a control write).
        cur_addr = 16'h0040; reads = 0; bytes = 0; latches = 0; frames = 0;
        write_reg(2'd0, 16'h0040);
        write_reg(2'd1, 16'd10);
        write_reg(2'd3, '0);
        while (bus_req) @(negedge clk);
        repeat (5) @(negedge clk);
        check(latches == 2 && frames == 1, "R8 default source frame", latches, 2);
        // R11: gray level.
        write_reg(2'd2, 16'h0006);
        @(negedge clk);
        check(lcd_gray == 2'd3, "R11 gray level", lcd_gray, 3);
        // R10: size zero go ignored.
        write_reg(2'd1, 16'd0);
        write_reg(2'd3, '0);
        repeat (4) @(negedge clk);
        check(!bus_req && !busy, "R10 zero size ignored", bus_req, 0);
        // Directed corners: one byte, exact line, R9 go during busy.
        run_frame(16'h00FF, 1, 1'b0, 1'b0);
        run_frame(16'h1230, LINE_BYTES, 1'b1, 1'b0);
        run_frame(16'hFFFC, 13, 1'b1, 1'b1);
        // Random frames.
        for (int i = 0; i < 25; i++) begin
            lf_div  = 2 + ($urandom % 8);
            tmr_div = 2 + ($urandom % 8);
            run_frame(ADDR_W'($urandom), 1 + ($urandom % 40), 1'($urandom), 1'($urandom % 4 == 0));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1CD5));
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule